// File: doc/BRIEF.md
# Shared Load/Store Queue Occupancy Manager

This block keeps the occupancy bookkeeping for a load queue and a store queue that several hardware threads share. Each cycle every thread may request one load-queue entry and one store-queue entry, and may return one of each. The block decides which requests are admitted. The decision follows a thread-sharing policy that is selected at run time. The block reports full, empty and free-entry status for each thread and for the whole structure, and whether the structure has drained.

The block also arbitrates a fixed number of load cache ports and store cache ports within each cycle. Each thread raises a port request, and grants go to the lowest-numbered requesters until the budget is spent. Nothing carries over into the next cycle. Queue contents, address matching and the memory side are handled elsewhere. Only counts and admission decisions live here.

Top module: `lsq_occupancy_mgr`

## Requirements
- R1: `policy_sel` encodes 0 = shared pool, 1 = equal split, 2 = fixed cap. The value 3 is illegal: it drives `policy_err` high and the block then behaves as the shared pool.
- R2: Under the shared pool, a thread's full flag for a queue equals that queue's global full condition (total occupancy across all threads reaches the depth), and one thread may fill the whole queue.
- R3: Under the equal split, each thread's limit is depth / THREADS. The thread's full flag rises when its own count reaches that limit, and further requests from that thread are refused.
- R4: Under the fixed cap, each thread's limit is THRESHOLD, and admission is still bounded by the queue depth. Elaboration fails unless THRESHOLD exceeds both queue depths.
- R5: `lsq_full` is high when either queue is globally full. `lsq_empty` is high only when both queues hold no entries from active threads.
- R6: A thread's free count is the smaller of (its limit minus its count, or 0 when it is full) and (depth minus total occupancy). `*_free_total` is the sum of these free counts over the threads marked active.
- R7: Within one cycle, port grants go to requesting threads in ascending index order, up to LD_PORTS for loads and ST_PORTS for stores. `*_port_avail` is high while the number of grants is below the budget, and no use carries into the next cycle.
- R8: `drained` is high only when every thread's load count and store count is zero, whether or not the thread is active.
- R9: A refused request leaves the counts unchanged and sets the queue's overflow flag (`ld_ovf`/`st_ovf`). The flag stays set until reset.
- R10: Requests made in the same cycle are admitted in ascending thread order against the occupancy at the start of the cycle. Releases take effect at the same edge, and a release from a thread with a zero count is ignored. `*_used_total` is the occupancy summed over active threads.
- R11: After reset all counts are zero, both overflow flags are low, `drained` and `lsq_empty` are high, and every free count equals the policy-limited room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 2 | Sharing policy select |
| thread_active | input | THREADS | Threads included in the summed totals |
| ld_alloc | input | THREADS | Per-thread load entry request |
| ld_release | input | THREADS | Per-thread load entry return |
| st_alloc | input | THREADS | Per-thread store entry request |
| st_release | input | THREADS | Per-thread store entry return |
| ld_port_req | input | THREADS | Per-thread load cache port request this cycle |
| st_port_req | input | THREADS | Per-thread store cache port request this cycle |
| ld_full_t | output | THREADS | Per-thread load-queue full (policy dependent) |
| st_full_t | output | THREADS | Per-thread store-queue full (policy dependent) |
| ld_free_t | output | THREADS*LCW | Per-thread load free count, thread t in bits [t*LCW +: LCW] |
| st_free_t | output | THREADS*SCW | Per-thread store free count, thread t in bits [t*SCW +: SCW] |
| ld_used_total | output | LTW | Load occupancy over active threads |
| st_used_total | output | STW | Store occupancy over active threads |
| ld_free_total | output | LTW | Summed load free count over active threads |
| st_free_total | output | STW | Summed store free count over active threads |
| lsq_full | output | 1 | Either queue globally full |
| lsq_empty | output | 1 | Both queues empty over active threads |
| drained | output | 1 | All counts of all threads zero |
| ld_ovf | output | 1 | Sticky: a load request was refused |
| st_ovf | output | 1 | Sticky: a store request was refused |
| policy_err | output | 1 | Illegal policy encoding |
| ld_port_gnt | output | THREADS | Load port grants this cycle |
| st_port_gnt | output | THREADS | Store port grants this cycle |
| ld_port_avail | output | 1 | Load port budget not exhausted |
| st_port_avail | output | 1 | Store port budget not exhausted |

## Verification
A corrupted per-thread count shows up at the ports one cycle after the faulty edge. It appears first in that thread's free count, then in the summed totals, and later as a full flag that rises too early or too late, or as a `drained` that never returns. An admission-order error shows as a wrong total in the cycle after two threads race for the last entry. A port-arbitration fault shows combinationally in the same cycle as the requests. The bench sweeps every policy, including the illegal code, over fill and drain phases with both active masks. It compares every output against counts it keeps itself.

// File: rtl/lsq_occ_pkg.sv
package lsq_occ_pkg;
  typedef enum logic [1:0] {
    POL_SHARED = 2'd0,
    POL_SPLIT  = 2'd1,
    POL_CAP    = 2'd2
  } share_pol_e;
endpackage

// File: rtl/lsq_port_arb.sv
module lsq_port_arb #(
  parameter int THREADS = 2,
  parameter int PORTS   = 1
) (
  input  logic [THREADS-1:0] req,
  output logic [THREADS-1:0] gnt,
  output logic               avail
);
  int n_used;

  // lowest index first until the per-cycle budget is spent
  always_comb begin
    n_used = 0;
    gnt    = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (req[t] && (n_used < PORTS)) begin
        gnt[t] = 1'b1;
        n_used = n_used + 1;
      end
    end
    avail = (n_used < PORTS);
  end
endmodule

// File: rtl/lsq_queue_ctr.sv
module lsq_queue_ctr
  import lsq_occ_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int DEPTH   = 8,
  parameter int THRESH  = 10,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(THREADS * DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            policy,
  input  logic [THREADS-1:0]    active,
  input  logic [THREADS-1:0]    alloc,
  input  logic [THREADS-1:0]    rel,
  output logic [THREADS-1:0]    thr_full,
  output logic [THREADS*CW-1:0] thr_free,
  output logic                  glob_full,
  output logic                  act_empty,
  output logic [TW-1:0]         used_total,
  output logic [TW-1:0]         free_total,
  output logic                  all_empty,
  output logic                  ovf
);
  logic [CW-1:0]      cnt_q [THREADS];
  logic [CW-1:0]      cnt_d [THREADS];
  logic               ovf_q, ovf_d;
  logic [THREADS-1:0] own_full;
  logic               upd_en;
  int                 limit_v;
  int                 all_v;

  // per-thread limit chosen by the sharing policy
  always_comb begin
    case (policy)
      POL_SPLIT: limit_v = DEPTH / THREADS;
      POL_CAP:   limit_v = THRESH;
      default:   limit_v = DEPTH;
    endcase
  end

  always_comb begin
    all_v = 0;
    for (int t = 0; t < THREADS; t++) all_v = all_v + int'(cnt_q[t]);
  end

  assign glob_full = (all_v >= DEPTH);

  always_comb begin
    int act_sum, free_sum, own_room, glob_room, f;
    act_sum  = 0;
    free_sum = 0;
    for (int t = 0; t < THREADS; t++) begin
      own_full[t] = (int'(cnt_q[t]) >= limit_v);
      if (policy == POL_SPLIT || policy == POL_CAP) thr_full[t] = own_full[t];
      else                                          thr_full[t] = glob_full;
      own_room  = own_full[t] ? 0 : (limit_v - int'(cnt_q[t]));
      glob_room = DEPTH - all_v;
      f = (own_room < glob_room) ? own_room : glob_room;
      thr_free[t*CW +: CW] = CW'(f);
      if (active[t]) begin
        act_sum  = act_sum + int'(cnt_q[t]);
        free_sum = free_sum + f;
      end
    end
    used_total = TW'(act_sum);
    free_total = TW'(free_sum);
    act_empty  = (act_sum == 0);
  end

  assign all_empty = (all_v == 0);
  assign ovf       = ovf_q;

  // admission in thread order against start-of-cycle occupancy
  always_comb begin
    int  acc;
    logic take, drop;
    acc   = all_v;
    ovf_d = ovf_q;
    for (int t = 0; t < THREADS; t++) begin
      take = alloc[t] && !own_full[t] && (acc < DEPTH);
      if (take) acc = acc + 1;
      if (alloc[t] && !take) ovf_d = 1'b1;
      drop = rel[t] && (cnt_q[t] != '0);
      cnt_d[t] = cnt_q[t] + CW'(take) - CW'(drop);
    end
  end

  assign upd_en = (|alloc) || (|rel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) cnt_q[t] <= '0;
      ovf_q <= 1'b0;
    end else if (upd_en) begin
      for (int t = 0; t < THREADS; t++) cnt_q[t] <= cnt_d[t];
      ovf_q <= ovf_d;
    end
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_v <= DEPTH);

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_full && !(|rel)) |=> $stable(all_v));
endmodule

// File: rtl/lsq_occupancy_mgr.sv
module lsq_occupancy_mgr
  import lsq_occ_pkg::*;
#(
  parameter int THREADS   = 2,
  parameter int LQ_DEPTH  = 8,
  parameter int SQ_DEPTH  = 4,
  parameter int THRESHOLD = 10,
  parameter int LD_PORTS  = 1,
  parameter int ST_PORTS  = 2,
  localparam int LCW = $clog2(LQ_DEPTH + 1),
  localparam int SCW = $clog2(SQ_DEPTH + 1),
  localparam int LTW = $clog2(THREADS * LQ_DEPTH + 1),
  localparam int STW = $clog2(THREADS * SQ_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             policy_sel,
  input  logic [THREADS-1:0]     thread_active,
  input  logic [THREADS-1:0]     ld_alloc,
  input  logic [THREADS-1:0]     ld_release,
  input  logic [THREADS-1:0]     st_alloc,
  input  logic [THREADS-1:0]     st_release,
  input  logic [THREADS-1:0]     ld_port_req,
  input  logic [THREADS-1:0]     st_port_req,
  output logic [THREADS-1:0]     ld_full_t,
  output logic [THREADS-1:0]     st_full_t,
  output logic [THREADS*LCW-1:0] ld_free_t,
  output logic [THREADS*SCW-1:0] st_free_t,
  output logic [LTW-1:0]         ld_used_total,
  output logic [STW-1:0]         st_used_total,
  output logic [LTW-1:0]         ld_free_total,
  output logic [STW-1:0]         st_free_total,
  output logic                   lsq_full,
  output logic                   lsq_empty,
  output logic                   drained,
  output logic                   ld_ovf,
  output logic                   st_ovf,
  output logic                   policy_err,
  output logic [THREADS-1:0]     ld_port_gnt,
  output logic [THREADS-1:0]     st_port_gnt,
  output logic                   ld_port_avail,
  output logic                   st_port_avail
);
  generate
    if (THRESHOLD <= LQ_DEPTH || THRESHOLD <= SQ_DEPTH) begin : g_bad_threshold
      $error("THRESHOLD must exceed both queue depths");
    end
  endgenerate

  logic ld_gfull, st_gfull, ld_aempty, st_aempty, ld_all_empty, st_all_empty;

  lsq_queue_ctr #(.THREADS(THREADS), .DEPTH(LQ_DEPTH), .THRESH(THRESHOLD)) ld_ctr_i (
    .clk(clk), .rst_n(rst_n), .policy(policy_sel), .active(thread_active),
    .alloc(ld_alloc), .rel(ld_release), .thr_full(ld_full_t), .thr_free(ld_free_t),
    .glob_full(ld_gfull), .act_empty(ld_aempty), .used_total(ld_used_total),
    .free_total(ld_free_total), .all_empty(ld_all_empty), .ovf(ld_ovf));

  lsq_queue_ctr #(.THREADS(THREADS), .DEPTH(SQ_DEPTH), .THRESH(THRESHOLD)) st_ctr_i (
    .clk(clk), .rst_n(rst_n), .policy(policy_sel), .active(thread_active),
    .alloc(st_alloc), .rel(st_release), .thr_full(st_full_t), .thr_free(st_free_t),
    .glob_full(st_gfull), .act_empty(st_aempty), .used_total(st_used_total),
    .free_total(st_free_total), .all_empty(st_all_empty), .ovf(st_ovf));

  lsq_port_arb #(.THREADS(THREADS), .PORTS(LD_PORTS)) ld_arb_i (
    .req(ld_port_req), .gnt(ld_port_gnt), .avail(ld_port_avail));

  lsq_port_arb #(.THREADS(THREADS), .PORTS(ST_PORTS)) st_arb_i (
    .req(st_port_req), .gnt(st_port_gnt), .avail(st_port_avail));

  assign lsq_full   = ld_gfull | st_gfull;
  assign lsq_empty  = ld_aempty & st_aempty;
  assign drained    = ld_all_empty & st_all_empty;
  assign policy_err = (policy_sel == 2'd3);

  // R7
  ld_port_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ld_port_gnt) <= LD_PORTS) && ((ld_port_gnt & ~ld_port_req) == '0));

  // R7
  st_port_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(st_port_gnt) <= ST_PORTS) && ((st_port_gnt & ~st_port_req) == '0));

  // R8
  drained_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> lsq_empty);
endmodule

// File: tb/lsq_occupancy_mgr_tb_top.sv
`timescale 1ns/1ps
module lsq_occupancy_mgr_tb_top;
  localparam int T = 2;
  localparam int LQD = 8, SQD = 4, THR = 10, LDP = 1, STP = 2;
  localparam int LCW = 4, SCW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] policy_sel;
  logic [T-1:0] thread_active, ld_alloc, ld_release, st_alloc, st_release, ld_port_req, st_port_req;
  logic [T-1:0] ld_full_t, st_full_t, ld_port_gnt, st_port_gnt;
  logic [T*LCW-1:0] ld_free_t;
  logic [T*SCW-1:0] st_free_t;
  logic [4:0] ld_used_total, ld_free_total;
  logic [3:0] st_used_total, st_free_total;
  logic lsq_full, lsq_empty, drained, ld_ovf, st_ovf, policy_err, ld_port_avail, st_port_avail;

  always #10 clk = ~clk;

  lsq_occupancy_mgr #(.THREADS(T), .LQ_DEPTH(LQD), .SQ_DEPTH(SQD), .THRESHOLD(THR),
                      .LD_PORTS(LDP), .ST_PORTS(STP)) dut_i (.*);

  int nchk = 0, nerr = 0;
  bit finished = 0;
  int mc [2][T];
  bit movf [2];
  int depth [2] = '{LQD, SQD};
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lim(int pol, int q);
    if (pol == 1) return depth[q] / T;
    if (pol == 2) return THR;
    return depth[q];
  endfunction

  task automatic check_all(int pol, bit at_reset);
    int all_q [2];
    bit gf [2], emp [2];
    string ftag;
    ftag = (pol == 1) ? "R3 thread full" : (pol == 2) ? "R4 thread full" : "R2 thread full";
    for (int q = 0; q < 2; q++) begin
      int used, fsum;
      all_q[q] = 0;
      for (int t = 0; t < T; t++) all_q[q] += mc[q][t];
      gf[q] = (all_q[q] >= depth[q]);
      used = 0; fsum = 0;
      for (int t = 0; t < T; t++) begin
        bit own, ef;
        int orm, grm, efree, afree;
        own = (mc[q][t] >= lim(pol, q));
        ef = (pol == 1 || pol == 2) ? own : gf[q];
        orm = own ? 0 : lim(pol, q) - mc[q][t];
        grm = depth[q] - all_q[q];
        efree = (orm < grm) ? orm : grm;
        if (thread_active[t]) begin used += mc[q][t]; fsum += efree; end
        afree = (q == 0) ? int'(ld_free_t[t*LCW +: LCW]) : int'(st_free_t[t*SCW +: SCW]);
        chk(at_reset ? "R11 thread free" : "R6 thread free", afree, efree);
        chk(ftag, (q == 0) ? int'(ld_full_t[t]) : int'(st_full_t[t]), int'(ef));
      end
      emp[q] = (used == 0);
      chk("R10 used total", (q == 0) ? int'(ld_used_total) : int'(st_used_total), used);
      chk("R6 free total", (q == 0) ? int'(ld_free_total) : int'(st_free_total), fsum);
      chk(at_reset ? "R11 overflow" : "R9 overflow", (q == 0) ? int'(ld_ovf) : int'(st_ovf), int'(movf[q]));
    end
    chk("R5 lsq_full", int'(lsq_full), int'(gf[0] | gf[1]));
    chk(at_reset ? "R11 lsq_empty" : "R5 lsq_empty", int'(lsq_empty), int'(emp[0] & emp[1]));
    chk(at_reset ? "R11 drained" : "R8 drained", int'(drained), int'(all_q[0] == 0 && all_q[1] == 0));
    chk("R1 policy_err", int'(policy_err), int'(pol == 3));
    begin
      int n; logic [T-1:0] g;
      n = 0; g = '0;
      for (int t = 0; t < T; t++) if (ld_port_req[t] && n < LDP) begin g[t] = 1; n++; end
      chk("R7 load grants", int'(ld_port_gnt), int'(g));
      chk("R7 load avail", int'(ld_port_avail), int'(n < LDP));
      n = 0; g = '0;
      for (int t = 0; t < T; t++) if (st_port_req[t] && n < STP) begin g[t] = 1; n++; end
      chk("R7 store grants", int'(st_port_gnt), int'(g));
      chk("R7 store avail", int'(st_port_avail), int'(n < STP));
    end
  endtask

  // R9 R10 model update for the coming edge
  task automatic model_step(int pol);
    for (int q = 0; q < 2; q++) begin
      int acc;
      logic [T-1:0] al, rl;
      al = (q == 0) ? ld_alloc : st_alloc;
      rl = (q == 0) ? ld_release : st_release;
      acc = 0;
      for (int t = 0; t < T; t++) acc += mc[q][t];
      for (int t = 0; t < T; t++) begin
        bit take, drop;
        take = al[t] && (mc[q][t] < lim(pol, q)) && (acc < depth[q]);
        if (take) acc++;
        if (al[t] && !take) movf[q] = 1;
        drop = rl[t] && (mc[q][t] != 0);
        mc[q][t] = mc[q][t] + int'(take) - int'(drop);
      end
    end
  endtask

  task automatic do_reset(int pol);
    @(negedge clk);
    rst_n = 1'b0;
    policy_sel = 2'(pol);
    ld_alloc = '0; ld_release = '0; st_alloc = '0; st_release = '0;
    ld_port_req = '0; st_port_req = '0; thread_active = '1;
    for (int q = 0; q < 2; q++) begin
      movf[q] = 0;
      for (int t = 0; t < T; t++) mc[q][t] = 0;
    end
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all(pol, 1'b1); // R11
  endtask

  task automatic run_phase(int pol, logic [T-1:0] act, int ncyc, bit fill);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      thread_active = act;
      for (int t = 0; t < T; t++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ld_alloc[t]   = fill ? (lfsr[1:0] != 0) : (lfsr[2:0] == 0);
        ld_release[t] = fill ? (lfsr[5:3] == 0) : (lfsr[4:3] != 0);
        st_alloc[t]   = fill ? (lfsr[7:6] != 0) : (lfsr[8:6] == 0);
        st_release[t] = fill ? (lfsr[11:9] == 0) : (lfsr[10:9] != 0);
        ld_port_req[t] = lfsr[12];
        st_port_req[t] = lfsr[14];
      end
      #1;
      check_all(pol, 1'b0);
      model_step(pol);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    policy_sel = '0;
    thread_active = '1;
    ld_alloc = '0; ld_release = '0; st_alloc = '0; st_release = '0;
    ld_port_req = '0; st_port_req = '0;
    for (int pol = 0; pol < 4; pol++) begin
      do_reset(pol);
      run_phase(pol, 2'b11, 50, 1'b1);
      run_phase(pol, 2'b11, 50, 1'b0);
      run_phase(pol, 2'b01, 40, 1'b1);
      run_phase(pol, 2'b10, 40, 1'b0);
      run_phase(pol, 2'b11, 30, 1'b0);
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule